// File: doc/BRIEF.md
# Byte/Word Addressable General Register File

This block is the general register storage of a 16-bit processor core. It keeps four general data registers, each of which can be handled as one 16-bit word or as two independent 8-bit halves. It also keeps four pointer/index registers that are handled only as whole words. A separate instruction pointer sits beside them and is reached only through its own load and fetch-advance controls.

Two combinational read ports and one clocked write port serve the execution datapath. Each port takes a 3-bit register code and a size flag that selects word or byte meaning for that code. The four pointer/index registers are also driven out continuously as 16-bit offsets for the address generation logic.

Reset is asynchronous and active low. It clears every register at once, and its release is synchronised to the clock by two flops.

Top module: `gpr_file`

## Requirements
- R1: While reset is held, and after it is released until the first write, every read returns zero, `ptr_offsets` is all zero and `ip_value` is zero.
- R2: A word write with a code of 0xx loads all 16 bits of a data register. The codes are 000, 001, 010 and 011, in that order. A word read with the same code returns that value.
- R3: A byte write with a code of 0xx replaces bits 7:0 of data register xx with `wr_data[7:0]`. Bits 15:8 of that register do not change.
- R4: A byte write with a code of 1xx replaces bits 15:8 of data register xx with `wr_data[7:0]`. Bits 7:0 of that register do not change.
- R5: A byte read returns the selected half in bits 7:0, with bits 15:8 at zero. Code 0xx selects the low half of data register xx and code 1xx selects its high half.
- R6: A word write or word read with a code of 1xx reaches pointer/index register xx. The codes are 100, 101, 110 and 111, in that order.
- R7: A byte access never reaches a pointer/index register. After a byte write with a code of 1xx, `ptr_offsets` is unchanged.
- R8: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R9: `ptr_offsets[16*k+15:16*k]` always shows pointer/index register k. It changes only on a word write to code 1k.
- R10: When `ip_load` is high, `ip_value` takes `ip_load_val` at the next edge.
- R11: When `ip_adv` is high and `ip_load` is low, `ip_value` grows by `ip_adv_amt` at the next edge, modulo 2^16.
- R12: When `ip_load` and `ip_adv` are high together, the load wins.
- R13: No general write changes `ip_value`. With both IP controls low, `ip_value` holds.
- R14: The two read ports select independently. Both can read different registers, or different sizes, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write register code |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| rd_a_sel | input | 3 | Read port A register code |
| rd_a_word | input | 1 | Read port A size, 1 = word |
| rd_a_data | output | 16 | Read port A value, with bytes zero-extended |
| rd_b_sel | input | 3 | Read port B register code |
| rd_b_word | input | 1 | Read port B size, 1 = word |
| rd_b_data | output | 16 | Read port B value, with bytes zero-extended |
| ptr_offsets | output | 64 | The four pointer/index registers, register k in bits 16k+15:16k |
| ip_load | input | 1 | Load the instruction pointer (jump) |
| ip_load_val | input | 16 | Jump target |
| ip_adv | input | 1 | Advance the instruction pointer |
| ip_adv_amt | input | 3 | Number of bytes fetched |
| ip_value | output | 16 | Current instruction pointer |

## Verification
The bound checker watches the instruction pointer on every cycle. It checks that a load lands, that an advance adds the fetch amount, that a load beats an advance, and that `ip_value` holds otherwise. On every cycle it also checks that the pointer offsets move only on a word write with a 1xx code, and that they take exactly the written value. Byte-half preservation in the data registers, the zero-extension of byte reads and the old-value read during a write are not visible at any single port, so they are shown only by the bench. The bench's reference model follows random and directed access sequences and compares both read ports every cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BYTE_W   = WORD_W / 2;
  localparam int unsigned NUM_DATA = 4;
  localparam int unsigned NUM_PTR  = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_DATA);
  localparam int unsigned SEL_W    = IDX_W + 1;
  localparam int unsigned NUM_RD   = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] half_t;
endpackage

// File: rtl/gpr_write_decode.sv
module gpr_write_decode
  import gpr_pkg::*;
(
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic                wr_word,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [NUM_DATA-1:0] lo_we,
  output logic [NUM_DATA-1:0] hi_we,
  output logic [NUM_PTR-1:0]  ptr_we,
  output logic [BYTE_W-1:0]   lo_val,
  output logic [BYTE_W-1:0]   hi_val,
  output logic [WORD_W-1:0]   ptr_val
);
  logic [IDX_W-1:0] idx;
  logic             upper;

  assign idx   = wr_sel[IDX_W-1:0];
  assign upper = wr_sel[SEL_W-1];

  always_comb begin
    lo_we   = '0;
    hi_we   = '0;
    ptr_we  = '0;
    lo_val  = wr_data[BYTE_W-1:0];
    hi_val  = wr_data[WORD_W-1:BYTE_W];
    ptr_val = wr_data;
    if (wr_en) begin
      if (wr_word) begin
        if (upper) begin
          ptr_we[idx] = 1'b1;
        end else begin
          lo_we[idx] = 1'b1;
          hi_we[idx] = 1'b1;
        end
      end else begin
        // byte codes address data halves only; upper bit picks the half
        if (upper) begin
          hi_we[idx] = 1'b1;
          hi_val     = wr_data[BYTE_W-1:0];
        end else begin
          lo_we[idx] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gpr_data_bank.sv
module gpr_data_bank
  import gpr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_DATA-1:0]            lo_we,
  input  logic [NUM_DATA-1:0]            hi_we,
  input  logic [BYTE_W-1:0]              lo_val,
  input  logic [BYTE_W-1:0]              hi_val,
  output logic [NUM_DATA-1:0][WORD_W-1:0] regs
);
  genvar g;
  generate
    for (g = 0; g < NUM_DATA; g++) begin : g_reg
      logic [BYTE_W-1:0] lo_q, lo_d;
      logic [BYTE_W-1:0] hi_q, hi_d;

      always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (lo_we[g]) lo_d = lo_val;
        if (hi_we[g]) hi_d = hi_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
        end else if (lo_we[g]) begin
          lo_q <= lo_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= '0;
        end else if (hi_we[g]) begin
          hi_q <= hi_d;
        end
      end

      assign regs[g] = {hi_q, lo_q};
    end
  endgenerate
endmodule

// File: rtl/gpr_ptr_bank.sv
module gpr_ptr_bank
  import gpr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PTR-1:0]            ptr_we,
  input  logic [WORD_W-1:0]             ptr_val,
  output logic [NUM_PTR-1:0][WORD_W-1:0] regs
);
  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_reg
      logic [WORD_W-1:0] q, d;

      always_comb begin
        d = q;
        if (ptr_we[g]) d = ptr_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (ptr_we[g]) begin
          q <= d;
        end
      end

      assign regs[g] = q;
    end
  endgenerate
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic [NUM_DATA-1:0][WORD_W-1:0] data_regs,
  input  logic [NUM_PTR-1:0][WORD_W-1:0]  ptr_regs,
  input  logic [SEL_W-1:0]                sel,
  input  logic                            word,
  output logic [WORD_W-1:0]               value
);
  logic [IDX_W-1:0]  idx;
  logic              upper;
  logic [WORD_W-1:0] dreg;

  assign idx   = sel[IDX_W-1:0];
  assign upper = sel[SEL_W-1];
  assign dreg  = data_regs[idx];

  always_comb begin
    if (word) begin
      value = upper ? ptr_regs[idx] : dreg;
    end else if (upper) begin
      value = {{(WORD_W-BYTE_W){1'b0}}, dreg[WORD_W-1:BYTE_W]};
    end else begin
      value = {{(WORD_W-BYTE_W){1'b0}}, dreg[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/gpr_ip_unit.sv
module gpr_ip_unit
  import gpr_pkg::*;
#(
  parameter int unsigned ADV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              adv,
  input  logic [ADV_W-1:0]  adv_amt,
  output logic [WORD_W-1:0] ip
);
  logic [WORD_W-1:0] ip_q, ip_d;
  logic              ip_en;

  assign ip_en = load | adv;

  always_comb begin
    ip_d = ip_q;
    if (load) begin
      ip_d = load_val;
    end else if (adv) begin
      ip_d = ip_q + WORD_W'(adv_amt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0;
    end else if (ip_en) begin
      ip_q <= ip_d;
    end
  end

  assign ip = ip_q;
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned ADV_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic                        wr_word,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]            rd_a_sel,
  input  logic                        rd_a_word,
  output logic [WORD_W-1:0]           rd_a_data,
  input  logic [SEL_W-1:0]            rd_b_sel,
  input  logic                        rd_b_word,
  output logic [WORD_W-1:0]           rd_b_data,
  output logic [NUM_PTR*WORD_W-1:0]   ptr_offsets,
  input  logic                        ip_load,
  input  logic [WORD_W-1:0]           ip_load_val,
  input  logic                        ip_adv,
  input  logic [ADV_W-1:0]            ip_adv_amt,
  output logic [WORD_W-1:0]           ip_value
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [NUM_DATA-1:0]             lo_we, hi_we;
  logic [NUM_PTR-1:0]              ptr_we;
  logic [BYTE_W-1:0]               lo_val, hi_val;
  logic [WORD_W-1:0]               ptr_val;
  logic [NUM_DATA-1:0][WORD_W-1:0] data_regs;
  logic [NUM_PTR-1:0][WORD_W-1:0]  ptr_regs;

  gpr_write_decode u_wdec (
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_word (wr_word),
    .wr_data (wr_data),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .ptr_we  (ptr_we),
    .lo_val  (lo_val),
    .hi_val  (hi_val),
    .ptr_val (ptr_val)
  );

  gpr_data_bank u_data (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lo_we  (lo_we),
    .hi_we  (hi_we),
    .lo_val (lo_val),
    .hi_val (hi_val),
    .regs   (data_regs)
  );

  gpr_ptr_bank u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ptr_we  (ptr_we),
    .ptr_val (ptr_val),
    .regs    (ptr_regs)
  );

  logic [NUM_RD-1:0][SEL_W-1:0]  rd_sel;
  logic [NUM_RD-1:0]             rd_word;
  logic [NUM_RD-1:0][WORD_W-1:0] rd_val;

  assign rd_sel  = {rd_b_sel, rd_a_sel};
  assign rd_word = {rd_b_word, rd_a_word};

  genvar p;
  generate
    for (p = 0; p < NUM_RD; p++) begin : g_rd
      gpr_read_port u_rp (
        .data_regs (data_regs),
        .ptr_regs  (ptr_regs),
        .sel       (rd_sel[p]),
        .word      (rd_word[p]),
        .value     (rd_val[p])
      );
    end
  endgenerate

  assign rd_a_data   = rd_val[0];
  assign rd_b_data   = rd_val[1];
  assign ptr_offsets = ptr_regs;

  gpr_ip_unit #(.ADV_W(ADV_W)) u_ip (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ip_load),
    .load_val (ip_load_val),
    .adv      (ip_adv),
    .adv_amt  (ip_adv_amt),
    .ip       (ip_value)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_pkg::*;
#(
  parameter int unsigned ADV_W = 3
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic                      wr_en,
  input logic [SEL_W-1:0]          wr_sel,
  input logic                      wr_word,
  input logic [WORD_W-1:0]         wr_data,
  input logic [NUM_PTR*WORD_W-1:0] ptr_offsets,
  input logic                      ip_load,
  input logic [WORD_W-1:0]         ip_load_val,
  input logic                      ip_adv,
  input logic [ADV_W-1:0]          ip_adv_amt,
  input logic [WORD_W-1:0]         ip_value
);
  logic ptr_word_wr;
  assign ptr_word_wr = wr_en && wr_word && wr_sel[SEL_W-1];

  // R10 and R12: a load always lands, even with an advance present
  p_ip_load_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ip_load |=> ip_value == $past(ip_load_val));

  // R11: the advance adds the fetch amount
  p_ip_adv_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ip_load && ip_adv) |=> ip_value == WORD_W'($past(ip_value) + WORD_W'($past(ip_adv_amt))));

  // R13: general writes never disturb the instruction pointer
  p_ip_hold_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ip_load && !ip_adv) |=> $stable(ip_value));

  // R7: byte writes never reach the pointer/index registers
  p_ptr_byte_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_word) |=> $stable(ptr_offsets));

  // R9: the offsets hold unless a word write with a 1xx code occurs
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ptr_word_wr |=> $stable(ptr_offsets));

  // R6: a word write with a 1xx code lands in the addressed pointer slot
  p_ptr_word_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ptr_word_wr |=> ptr_offsets[$past(wr_sel[IDX_W-1:0])*WORD_W +: WORD_W] == $past(wr_data));
endmodule

bind gpr_file gpr_file_chk #(.ADV_W(ADV_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_word     (wr_word),
  .wr_data     (wr_data),
  .ptr_offsets (ptr_offsets),
  .ip_load     (ip_load),
  .ip_load_val (ip_load_val),
  .ip_adv      (ip_adv),
  .ip_adv_amt  (ip_adv_amt),
  .ip_value    (ip_value)
);

// File: tb/sim_gpr_file.sv
module sim_gpr_file;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic        wr_word;
  logic [15:0] wr_data;
  logic [2:0]  rd_a_sel;
  logic        rd_a_word;
  logic [15:0] rd_a_data;
  logic [2:0]  rd_b_sel;
  logic        rd_b_word;
  logic [15:0] rd_b_data;
  logic [63:0] ptr_offsets;
  logic        ip_load;
  logic [15:0] ip_load_val;
  logic        ip_adv;
  logic [2:0]  ip_adv_amt;
  logic [15:0] ip_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_data [4];
  logic [15:0] m_ptr  [4];
  logic [15:0] m_ip;
  string       ip_tag;

  gpr_file u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_word(wr_word), .wr_data(wr_data),
    .rd_a_sel(rd_a_sel), .rd_a_word(rd_a_word), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_word(rd_b_word), .rd_b_data(rd_b_data),
    .ptr_offsets(ptr_offsets),
    .ip_load(ip_load), .ip_load_val(ip_load_val),
    .ip_adv(ip_adv), .ip_adv_amt(ip_adv_amt), .ip_value(ip_value)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] exp_rd(logic [2:0] s, logic w);
    if (w) return s[2] ? m_ptr[s[1:0]] : m_data[s[1:0]];
    if (s[2]) return {8'h00, m_data[s[1:0]][15:8]};
    return {8'h00, m_data[s[1:0]][7:0]};
  endfunction

  function automatic string rd_tag(logic [2:0] s, logic w);
    if (wr_en && (wr_word == w) && (wr_sel == s)) return "R8";
    if (!w) return "R5";
    return s[2] ? "R6" : "R2";
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(rd_tag(rd_a_sel, rd_a_word), rd_a_data, exp_rd(rd_a_sel, rd_a_word));
    chk("R14", rd_b_data, exp_rd(rd_b_sel, rd_b_word));
    for (int k = 0; k < 4; k++) chk("R9", ptr_offsets[16*k +: 16], m_ptr[k]);
    chk(ip_tag, ip_value, m_ip);
  endtask

  task automatic model_update();
    if (wr_en) begin
      if (wr_word) begin
        if (wr_sel[2]) m_ptr[wr_sel[1:0]] = wr_data;
        else m_data[wr_sel[1:0]] = wr_data;
      end else if (wr_sel[2]) begin
        m_data[wr_sel[1:0]][15:8] = wr_data[7:0];
      end else begin
        m_data[wr_sel[1:0]][7:0] = wr_data[7:0];
      end
    end
    if (ip_load) m_ip = ip_load_val;
    else if (ip_adv) m_ip = m_ip + 16'(ip_adv_amt);
    if (ip_load && ip_adv) ip_tag = "R12";
    else if (ip_load) ip_tag = "R10";
    else if (ip_adv) ip_tag = "R11";
    else ip_tag = "R13";
  endtask

  task automatic step(logic we, logic [2:0] ws, logic ww, logic [15:0] wd,
                      logic [2:0] as, logic aw, logic [2:0] bs, logic bw,
                      logic il, logic [15:0] iv, logic ia, logic [2:0] am);
    wr_en = we; wr_sel = ws; wr_word = ww; wr_data = wd;
    rd_a_sel = as; rd_a_word = aw; rd_b_sel = bs; rd_b_word = bw;
    ip_load = il; ip_load_val = iv; ip_adv = ia; ip_adv_amt = am;
    #1;
    check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 4; k++) begin m_data[k] = '0; m_ptr[k] = '0; end
    m_ip = '0;
    ip_tag = "R1";
    rst_n = 1'b0;
    wr_en = 0; wr_sel = 0; wr_word = 0; wr_data = 0;
    rd_a_sel = 0; rd_a_word = 0; rd_b_sel = 0; rd_b_word = 0;
    ip_load = 0; ip_load_val = 0; ip_adv = 0; ip_adv_amt = 0;
    repeat (3) @(negedge clk);
    // R1: everything reads zero while reset is held
    for (int c = 0; c < 8; c++) begin
      rd_a_sel = 3'(c); rd_a_word = 1'b1; rd_b_sel = 3'(c); rd_b_word = 1'b0;
      #1;
      chk("R1", rd_a_data, 16'h0000);
      chk("R1", rd_b_data, 16'h0000);
    end
    chk("R1", ptr_offsets[15:0], 16'h0000);
    chk("R1", ip_value, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: word writes into the data registers
    step(1, 3'b000, 1, 16'h1234, 3'b000, 1, 3'b011, 1, 0, 0, 0, 0);
    step(1, 3'b011, 1, 16'hBEEF, 3'b000, 1, 3'b000, 0, 0, 0, 0, 0);
    // R4: high byte write keeps the low byte
    step(1, 3'b100, 0, 16'h0026, 3'b100, 0, 3'b000, 1, 0, 0, 0, 0);
    step(0, 3'b000, 0, 16'h0000, 3'b000, 1, 3'b100, 0, 0, 0, 0, 0);
    chk("R4", rd_a_data, 16'h2634);
    // R3: low byte write keeps the high byte
    step(1, 3'b011, 0, 16'hFF55, 3'b011, 1, 3'b111, 0, 0, 0, 0, 0);
    step(0, 3'b000, 0, 16'h0000, 3'b011, 1, 3'b011, 0, 0, 0, 0, 0);
    chk("R3", rd_a_data, 16'hBE55);
    chk("R5", rd_b_data, 16'h0055);
    // R6 and R7: pointer word write, then a byte write with the same code
    step(1, 3'b110, 1, 16'h1000, 3'b110, 1, 3'b110, 0, 0, 0, 0, 0);
    step(1, 3'b110, 0, 16'h00AA, 3'b110, 1, 3'b110, 0, 0, 0, 0, 0);
    chk("R7", ptr_offsets[47:32], 16'h1000);
    chk("R7", rd_b_data, 16'h00AA);
    // R8: reading the register being written shows the old value first
    step(1, 3'b001, 1, 16'hCAFE, 3'b001, 1, 3'b101, 0, 0, 0, 0, 0);
    #1 chk("R8", rd_a_data, 16'hCAFE);
    // R10, R11 wrap, R12 priority, R13 isolation
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 16'hFFFE, 0, 0);
    step(1, 3'b111, 1, 16'h7777, 0, 1, 0, 1, 0, 0, 1, 3'd5);
    chk("R11", ip_value, 16'h0003);
    step(1, 3'b010, 1, 16'h9999, 0, 1, 0, 1, 1, 16'h4000, 1, 3'd6);
    chk("R12", ip_value, 16'h4000);
    step(1, 3'b101, 1, 16'h5555, 0, 1, 0, 1, 0, 0, 0, 3'd7);
    chk("R13", ip_value, 16'h4000);

    // random mix, model-checked every cycle
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom), 3'($urandom), 1'($urandom), 16'($urandom),
           3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
           1'($urandom_range(0, 7) == 0), 16'($urandom),
           1'($urandom), 3'($urandom));
    end
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule